// File: doc/BRIEF.md
# Transmit DMA Buffer FIFO Bridge

This block sits on the transmit side between a host or DMA controller and a serial port transmitter. It buffers 32-bit words written by the host and hands them to the serial port in bursts of a programmed length. It also translates DMA requests between the two sides. A single control register enables the buffer, sets the burst length delivered to the port, sets the free-space threshold that drives host requests, and holds a sticky overflow flag.

While the buffer is disabled, the block is transparent. The port's transmit DMA request appears unchanged on the host request output, and host data writes have no effect. Once enabled, port requests are absorbed and counted as pending. Each pending request is served by one burst, which starts only after the FIFO holds at least the burst length. The host request then becomes a registered level that shows whether enough free space is available. The port side generates its requests in the same way in both modes.

Top module: `tbf_bridge`

## Requirements
- R1: After reset the block is disabled, `cfg_rdata` reads zero, `port_valid` and `port_data` are zero, and `host_req` equals `port_req`.
- R2: While disabled, `host_req` equals `port_req` in the same cycle, and `host_wr` stores nothing and never sets the overflow flag.
- R3: While enabled, `port_req` has no direct effect on `host_req`.
- R4: A burst delivers exactly the effective burst length of words on consecutive cycles, with `port_valid` high and the words in write order. `port_data` is zero whenever `port_valid` is low. The first word appears two clock edges after the edge that samples the port request, provided enough words are already held.
- R5: If the FIFO holds fewer words than the effective burst length, the request stays pending. The full burst starts on the edge after the count reaches the length. Requests are counted up to 255, and each one is served by its own burst.
- R6: A host write is stored when the FIFO held fewer than DEPTH words before the edge. Otherwise it is dropped, even if a word leaves the FIFO in that same cycle.
- R7: While enabled, `host_req` is a registered level. It is high in a cycle when, at the previous edge, the block was enabled and the free space was at least the effective host burst count. It is therefore high on the second edge after enabling.
- R8: In both burst fields, a value of zero acts as one and a value above DEPTH acts as DEPTH. The raw value is still read back.
- R9: Writing bit 0 as zero empties the FIFO and cancels pending requests and any remaining burst at that edge. After a later re-enable, no old word is delivered.
- R10: Bit 31 is set by any write dropped while enabled and stays set. Writing 1 to bit 31 clears it, but a drop in the same cycle wins.
- R11: Register layout, on both write and read: bit 0 is enable, bits 15:8 are the port burst length, and bits 23:16 are the host burst count. Bit 31 reads as the overflow flag. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | DW | Host data word |
| host_req | output | 1 | Transmit DMA request toward the host |
| port_req | input | 1 | Transmit DMA request from the serial port |
| port_valid | output | 1 | Burst word valid toward the serial port |
| port_data | output | DW | Burst word toward the serial port |

## Verification
The assertions check the following on every cycle:
- The storage never accepts a word when full and never releases one when empty.
- A disabled block holds no words, no pending requests and no open burst.
- A port word never appears unless the block was enabled.
- The overflow flag sets on a drop and clears on a write-one.

Some behaviour only the bench scenarios can show. These are the burst lengths and word order, the deferral of a request until enough words arrive, the clamping of both fields, and the one-cycle timing of the host request after enabling. The bench shows them by comparing every output against a queue-based model, across directed sequences and a long random run.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

    typedef struct packed {
        logic       en;
        logic [7:0] port_burst;
        logic [7:0] host_burst;
        logic       ovf;
    } ctrl_t;

    // Zero counts as one, anything above the depth counts as the depth.
    function automatic int unsigned eff_burst(input logic [7:0] field, input int unsigned depth);
        if (field == 8'd0)
            return 1;
        else if (int'(field) > int'(depth))
            return depth;
        else
            return int'(field);
    endfunction

endpackage

// File: rtl/tbf_ctrl.sv
module tbf_ctrl
    import tbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        drop,
    output logic        en,
    output logic        en_next,
    output logic [7:0]  port_burst,
    output logic [7:0]  host_burst,
    output logic        ovf
);

    ctrl_t st_d, st_q;
    logic  unused_bits;

    assign unused_bits = ^{cfg_wdata[30:24], cfg_wdata[7:1]};

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.en         = cfg_wdata[0];
            st_d.port_burst = cfg_wdata[15:8];
            st_d.host_burst = cfg_wdata[23:16];
            if (cfg_wdata[31])
                st_d.ovf = 1'b0;
        end
        if (drop)
            st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en         = st_q.en;
    assign en_next    = st_d.en;
    assign port_burst = st_q.port_burst;
    assign host_burst = st_q.host_burst;
    assign ovf        = st_q.ovf;

    assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);

    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[31] && !drop) |=> !ovf);

endmodule

// File: rtl/tbf_store.sv
module tbf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1))
            return '0;
        else
            return p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = bump(st_q.wp);
        end
        if (pop)
            st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign head  = st_q.mem[st_q.rp];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

endmodule

// File: rtl/tbf_seq.sv
module tbf_seq #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          port_req,
    input  logic [CW-1:0] port_len,
    input  logic [CW-1:0] host_len,
    input  logic [CW-1:0] count,
    input  logic [DW-1:0] head,
    output logic          pop,
    output logic          port_valid,
    output logic [DW-1:0] port_data,
    output logic          hreq
);

    typedef struct packed {
        logic [7:0]    pend;
        logic [CW-1:0] rem;
        logic          vld;
        logic [DW-1:0] dat;
        logic          hreq;
    } seq_t;

    seq_t st_d, st_q;
    logic start;
    logic inc;

    assign pop   = en && (st_q.rem != '0);
    assign inc   = en && port_req;
    assign start = en && (st_q.rem == '0) && (st_q.pend != 8'd0) && (count >= port_len);

    always_comb begin
        st_d = st_q;
        if (inc && st_q.pend != 8'hFF)
            st_d.pend = st_d.pend + 8'd1;
        if (start) begin
            st_d.pend = st_d.pend - 8'd1;
            st_d.rem  = port_len;
        end else if (st_q.rem != '0) begin
            st_d.rem = st_q.rem - CW'(1);
        end
        st_d.vld  = pop;
        st_d.dat  = pop ? head : '0;
        st_d.hreq = en && ((CW'(DEPTH) - count) >= host_len);
        if (flush) begin
            st_d.pend = '0;
            st_d.rem  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign port_valid = st_q.vld;
    assign port_data  = st_q.dat;
    assign hreq       = st_q.hreq;

    assert_port_word_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |-> $past(en));

    assert_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (st_q.pend == 8'd0 && st_q.rem == '0 && count == '0));

    assert_burst_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.rem != '0) |=> port_valid);

endmodule

// File: rtl/tbf_bridge.sv
module tbf_bridge
    import tbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_req,
    input  logic          port_req,
    output logic          port_valid,
    output logic [DW-1:0] port_data
);

    logic          en, en_next, ovf;
    logic [7:0]    port_burst, host_burst;
    logic [CW-1:0] port_len, host_len, count;
    logic [DW-1:0] head;
    logic          push, pop, drop, flush, hreq;
    logic          full;

    assign full  = (count == CW'(DEPTH));
    assign push  = en && host_wr && !full;
    assign drop  = en && host_wr && full;
    assign flush = !en_next;

    assign port_len = CW'(eff_burst(port_burst, DEPTH));
    assign host_len = CW'(eff_burst(host_burst, DEPTH));

    tbf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .drop       (drop),
        .en         (en),
        .en_next    (en_next),
        .port_burst (port_burst),
        .host_burst (host_burst),
        .ovf        (ovf)
    );

    tbf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (host_wdata),
        .pop       (pop),
        .flush     (flush),
        .count     (count),
        .head      (head)
    );

    tbf_seq #(.DEPTH(DEPTH), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .flush      (flush),
        .port_req   (port_req),
        .port_len   (port_len),
        .host_len   (host_len),
        .count      (count),
        .head       (head),
        .pop        (pop),
        .port_valid (port_valid),
        .port_data  (port_data),
        .hreq       (hreq)
    );

    assign host_req  = en ? hreq : port_req;
    assign cfg_rdata = {ovf, 7'd0, host_burst, port_burst, 7'd0, en};

endmodule

// File: tb/test_tbf_bridge.sv
module test_tbf_bridge;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_req;
    logic        port_req = 1'b0;
    logic        port_valid;
    logic [31:0] port_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tbf_bridge #(.DEPTH(D), .DW(32)) i_tbf_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_req(host_req), .port_req(port_req), .port_valid(port_valid),
        .port_data(port_data)
    );

    // Behavioural reference model
    bit          m_en, m_ovf, m_vld, m_hreq;
    int          m_wn, m_hb, m_pend, m_rem;
    logic [31:0] m_dat;
    logic [31:0] q[$];
    int          burst_words = 0;

    function automatic int eff(input int f);
        if (f == 0) return 1;
        if (f > D) return D;
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ovf = 0; m_vld = 0; m_hreq = 0;
            m_wn = 0; m_hb = 0; m_pend = 0; m_rem = 0; m_dat = '0;
            q.delete();
        end else begin
            bit full, st, n_en;
            int n_wn, n_hb, n_pend;
            full = (q.size() == D);
            st = m_en && m_rem == 0 && m_pend > 0 && q.size() >= eff(m_wn);
            m_hreq = m_en && ((D - q.size()) >= eff(m_hb));
            n_pend = m_pend;
            if (m_en && port_req && n_pend < 255) n_pend++;
            if (m_en && m_rem > 0) begin
                m_vld = 1; m_dat = q.pop_front();
            end else begin
                m_vld = 0; m_dat = '0;
            end
            if (m_en && host_wr && !full) q.push_back(host_wdata);
            n_en = m_en; n_wn = m_wn; n_hb = m_hb;
            if (cfg_wr) begin
                n_en = cfg_wdata[0]; n_wn = cfg_wdata[15:8]; n_hb = cfg_wdata[23:16];
                if (cfg_wdata[31]) m_ovf = 0;
            end
            if (m_en && host_wr && full) m_ovf = 1;
            if (st) begin
                n_pend--; m_rem = eff(m_wn);
            end else if (m_rem > 0) m_rem--;
            m_pend = n_pend;
            if (!n_en) begin
                q.delete(); m_pend = 0; m_rem = 0;
            end
            m_en = n_en; m_wn = n_wn; m_hb = n_hb;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] rd;
        rd = {m_ovf, 7'd0, 8'(m_hb), 8'(m_wn), 7'd0, m_en};
        chk("R2 R3 R7 host_req", 32'(host_req), 32'(m_en ? m_hreq : port_req));
        chk("R4 R5 port_valid", 32'(port_valid), 32'(m_vld));
        chk("R4 port_data", port_data, m_dat);
        chk("R10 R11 cfg_rdata", cfg_rdata, rd);
        if (port_valid) burst_words++;
    endtask

    task automatic step(input bit pr, input bit hw, input logic [31:0] hd,
                        input bit cw, input logic [31:0] cd);
        @(negedge clk);
        if (rst_n) compare();
        port_req = pr; host_wr = hw; host_wdata = hd; cfg_wr = cw; cfg_wdata = cd;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0);
    endtask

    function automatic logic [31:0] cfg(input bit en, input int wn, input int hb, input bit clr);
        return {clr, 7'd0, 8'(hb), 8'(wn), 7'd0, en};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 cfg_rdata", cfg_rdata, '0);
        chk("R1 port_valid", 32'(port_valid), 0);
        chk("R1 port_data", port_data, '0);
        port_req = 1; #1;
        chk("R1 host_req follows", 32'(host_req), 1);
        port_req = 0;
        @(negedge clk); rst_n = 1;

        // R2: disabled pass-through, writes ignored
        for (int i = 0; i < 6; i++) step(i[0], 1, 32'hA000 + i, 0, '0);
        step(1, 0, '0, 0, '0);
        chk("R2 same-cycle pass", 32'(host_req), 1);
        idle(3);
        chk("R2 no overflow when off", 32'(cfg_rdata[31]), 0);

        // R7: enable, host burst 4, port burst 4
        step(0, 0, '0, 1, cfg(1, 4, 4, 0));
        step(0, 0, '0, 0, '0);
        chk("R7 not yet", 32'(host_req), 0);
        step(0, 0, '0, 0, '0);
        chk("R7 high after enable", 32'(host_req), 1);

        // R5: request with only 3 words, then the 4th
        for (int i = 0; i < 3; i++) step(0, 1, 32'h100 + i, 0, '0);
        step(1, 0, '0, 0, '0);
        burst_words = 0;
        idle(5);
        chk("R5 deferred", 32'(burst_words), 0);
        step(0, 1, 32'h103, 0, '0);
        idle(8);
        chk("R4 burst length", 32'(burst_words), 4);

        // R6 R10: overfill, drop, and sticky flag
        for (int i = 0; i < D + 3; i++) step(0, 1, 32'h200 + i, 0, '0);
        step(1, 0, '0, 0, '0);
        chk("R3 port_req not forwarded when full", 32'(host_req), 0);
        idle(2);
        chk("R6 R10 overflow set", 32'(cfg_rdata[31]), 1);
        idle(10);
        chk("R10 sticky", 32'(cfg_rdata[31]), 1);
        step(0, 0, '0, 1, cfg(1, 4, 4, 1));
        idle(1);
        chk("R10 cleared", 32'(cfg_rdata[31]), 0);

        // R8: zero field acts as one
        step(0, 0, '0, 1, cfg(1, 0, 0, 0));
        idle(2);
        burst_words = 0;
        step(1, 0, '0, 0, '0);
        idle(6);
        chk("R8 zero gives one", 32'(burst_words), 1);
        // R8: oversize field acts as depth
        step(0, 0, '0, 1, cfg(1, 200, 200, 0));
        for (int i = 0; i < 20; i++) step(0, 1, 32'h300 + i, 0, '0);
        idle(2);
        burst_words = 0;
        step(1, 0, '0, 0, '0);
        idle(D + 6);
        chk("R8 clamp to depth", 32'(burst_words), D);

        // R9: disable flushes, nothing old emerges after re-enable
        for (int i = 0; i < 5; i++) step(0, 1, 32'h400 + i, 0, '0);
        step(1, 0, '0, 0, '0);
        step(0, 0, '0, 1, cfg(0, 2, 2, 0));
        step(0, 0, '0, 1, cfg(1, 2, 2, 0));
        burst_words = 0;
        step(1, 0, '0, 0, '0);
        idle(6);
        chk("R9 flushed", 32'(burst_words), 0);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            bit cw;
            logic [31:0] cd;
            cw = ($urandom_range(0, 60) == 0);
            cd = cfg($urandom_range(0, 7) != 0, $urandom_range(0, 20),
                     $urandom_range(0, 20), $urandom_range(0, 1) == 1);
            step($urandom_range(0, 9) == 0, $urandom_range(0, 2) == 0,
                 $urandom, cw, cd);
        end
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule